// File: doc/BRIEF.md
# Byte-Count Packing Data FIFO

This block is a byte-wide buffer of 64 entries placed between a 32-bit register port and a serial engine. On the register side, each write to the data port pushes 1 to 4 bytes taken from the 32-bit word. Each read pops 1 to 4 bytes and returns them packed into a word. A separate byte-count register sets how many bytes each access moves. The last part of a transfer whose length is not a multiple of four is moved by lowering the byte count to the 1 to 3 remaining bytes before the final access. No padding ever enters the buffer.

The engine side has a single-byte push handshake and a single-byte pop handshake. Both sides may act in the same cycle. A status word carries three fields: the fill level, and sticky flags for register pushes that found no room and register pops that found no data. Free space is the depth minus the reported level. A flush input empties the buffer and clears both flags.

Top module: `byte_pack_fifo`

## Requirements
- R1: After reset, `stat_o` is zero, `cnt_o` is 4, `rdata_o` is zero, `eng_push_rdy_o` is 1 and `eng_pop_vld_o` is 0.
- R2: A write to the byte-count register with a value from 1 to 4 is taken at the next clock edge and shows on `cnt_o`. The values 0 and 5 to 7 are ignored, and the register keeps its previous value.
- R3: A data-port write pushes the low `cnt_o` bytes of `wdata_i` in little-endian order: bits [7:0] go in first, then bits [15:8], and so on.
- R4: A data-port read pops `cnt_o` bytes. The oldest byte lands in `rdata_o[7:0]`, the next in [15:8], and so on, and the unused upper bytes read as zero. `rdata_o` changes at the clock edge that takes the read and holds its value in every other cycle.
- R5: `stat_o[7:0]` gives the fill level. It changes at the clock edge that takes an operation, and it counts register and engine pushes and pops made in the same cycle together.
- R6: `eng_push_rdy_o` is 1 exactly when the level is below 64, and a byte is taken when `eng_push_i` and `eng_push_rdy_o` are both 1. An engine byte pushed in the same cycle as a register write is stored ahead of the register bytes.
- R7: `eng_pop_vld_o` is 1 exactly when the level is above 0, and `eng_dout_o` shows the oldest byte. An engine pop in the same cycle as a register read takes the oldest byte, and the register read takes the bytes that follow it.
- R8: A register write with more bytes than the free space stores the bytes that fit, drops the rest and sets the sticky overflow flag `stat_o[8]`.
- R9: A register read of more bytes than the level returns the bytes that are present, fills the remaining requested lanes with zero and sets the sticky underflow flag `stat_o[9]`.
- R10: `flush_i` empties the buffer and clears both flags at the next edge. Data-port and engine operations in the same cycle are ignored, and `rdata_o` holds its value.
- R11: When `wr_i` and `rd_i` are both 1, the write is performed and the read is ignored, so nothing is popped and `rdata_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Buffer reset: empties the buffer and clears the flags |
| cnt_we_i | input | 1 | Write strobe for the byte-count register |
| cnt_wdata_i | input | 3 | New byte count (1 to 4 accepted) |
| cnt_o | output | 3 | Current byte count |
| wr_i | input | 1 | Data-port write (push) |
| wdata_i | input | 32 | Data-port write word |
| rd_i | input | 1 | Data-port read (pop) |
| rdata_o | output | 32 | Word returned by the last data-port read |
| stat_o | output | 32 | [7:0] level, [8] overflow, [9] underflow, all other bits zero |
| eng_push_i | input | 1 | Engine pushes one byte |
| eng_din_i | input | 8 | Engine push byte |
| eng_push_rdy_o | output | 1 | Buffer has room for an engine byte |
| eng_pop_i | input | 1 | Engine pops one byte |
| eng_dout_o | output | 8 | Oldest byte in the buffer |
| eng_pop_vld_o | output | 1 | Buffer holds at least one byte |

## Verification
The assertions check a set of rules on every cycle. The byte count always stays between 1 and 4. The level never exceeds the depth and moves by no more than five bytes per cycle. A full buffer with no pops stays full. A flush always leaves the buffer empty. Both flags stay set until a flush. `rdata_o` changes only on a read that is taken, and a one-byte read returns zero in its upper lanes. Only the bench's scenarios can show that bytes come out in the right order and in the right lanes: little-endian packing across mixed byte counts, the engine byte placed ahead of register bytes in the same cycle, the partial store at the full boundary, the zero fill on a short read, and write-over-read priority.

// File: rtl/pack_fifo_pkg.sv
package pack_fifo_pkg;
  localparam int WORD_BYTES   = 4;
  localparam int STAT_LVL_W   = 8;
  localparam int STAT_OVF_BIT = 8;
  localparam int STAT_UNF_BIT = 9;
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/pack_fifo_bcnt.sv
module pack_fifo_bcnt #(
  parameter int WB = 4,
  localparam int CNT_W = $clog2(WB + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             legal;

  assign legal = (wdata_i != '0) && (int'(wdata_i) <= WB);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= CNT_W'(WB);
    else if (we_i && legal) cnt_q <= wdata_i;
  end

  assign cnt_o = cnt_q;

  assert_cnt_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) && (int'(cnt_q) <= WB));
  assert_cnt_illegal_kept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (wdata_i == '0)) |=> $stable(cnt_q));
endmodule

// File: rtl/pack_fifo_store.sv
module pack_fifo_store #(
  parameter int DEPTH = 64,
  parameter int LANES = 5,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int N_W   = $clog2(LANES + 1),
  localparam int LN_W  = $clog2(LANES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [PTR_W-1:0]      wr_ptr_i,
  input  logic [N_W-1:0]        n_wr_i,
  input  logic [LANES-1:0][7:0] wlanes_i,
  input  logic [PTR_W-1:0]      rd_ptr_i,
  output logic [LANES-1:0][7:0] rlanes_o
);
  logic [7:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [7:0]      q;
    logic            hit;
    logic [LN_W-1:0] sel;

    // distance of this slot from the write pointer, modulo depth
    always_comb begin
      int o;
      o = i - int'(wr_ptr_i);
      if (o < 0) o = o + DEPTH;
      hit = o < int'(n_wr_i);
      sel = LN_W'(o);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  q <= '0;
      else if (hit) q <= wlanes_i[sel];
    end

    assign mem[i] = q;
  end

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      int idx;
      idx = int'(rd_ptr_i) + k;
      if (idx >= DEPTH) idx = idx - DEPTH;
      rlanes_o[k] = mem[PTR_W'(idx)];
    end
  end
endmodule

// File: rtl/pack_fifo_ctrl.sv
module pack_fifo_ctrl #(
  parameter int DEPTH = 64,
  parameter int WB    = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int CNT_W = $clog2(WB + 1),
  localparam int LANES = WB + 1,
  localparam int N_W   = $clog2(LANES + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  flush_i,
  input  logic                  reg_wr_i,
  input  logic                  reg_rd_i,
  input  logic [CNT_W-1:0]      cnt_i,
  input  logic [8*WB-1:0]       wdata_i,
  input  logic                  eng_push_i,
  input  logic [7:0]            eng_din_i,
  input  logic                  eng_pop_i,
  output logic                  eng_push_rdy_o,
  output logic                  eng_pop_vld_o,
  output logic [PTR_W-1:0]      wr_ptr_o,
  output logic [PTR_W-1:0]      rd_ptr_o,
  output logic [N_W-1:0]        n_wr_o,
  output logic [LANES-1:0][7:0] wlanes_o,
  output logic                  rd_fire_o,
  output logic                  rd_off_o,
  output logic [CNT_W-1:0]      rd_cnt_o,
  output logic [LVL_W-1:0]      level_o,
  output logic                  ovf_o,
  output logic                  unf_o
);
  logic [LVL_W-1:0] level_q, free, room, avail, req_w, req_r, w_acc, r_acc;
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic             ovf_q, unf_q, act, e_in, e_out, ovf_hit, unf_hit;
  logic [N_W-1:0]   n_wr, n_rd;

  function automatic logic [PTR_W-1:0] wrap_add(input logic [PTR_W-1:0] p,
                                               input logic [N_W-1:0] n);
    int s;
    s = int'(p) + int'(n);
    if (s >= DEPTH) s = s - DEPTH;
    return PTR_W'(s);
  endfunction

  assign act            = ~flush_i;
  assign eng_push_rdy_o = (level_q != LVL_W'(DEPTH));
  assign eng_pop_vld_o  = (level_q != '0);

  // engine byte ranks first on both sides
  assign e_in  = act & eng_push_i & eng_push_rdy_o;
  assign e_out = act & eng_pop_i & eng_pop_vld_o;

  assign free    = LVL_W'(DEPTH) - level_q;
  assign room    = free - LVL_W'(e_in);
  assign req_w   = (act & reg_wr_i) ? LVL_W'(cnt_i) : '0;
  assign ovf_hit = req_w > room;
  assign w_acc   = ovf_hit ? room : req_w;

  assign avail   = level_q - LVL_W'(e_out);
  assign req_r   = (act & reg_rd_i) ? LVL_W'(cnt_i) : '0;
  assign unf_hit = req_r > avail;
  assign r_acc   = unf_hit ? avail : req_r;

  assign n_wr = N_W'(w_acc) + N_W'(e_in);
  assign n_rd = N_W'(r_acc) + N_W'(e_out);

  assign wlanes_o = e_in ? {wdata_i, eng_din_i} : {8'h00, wdata_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q  <= '0;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      ovf_q    <= 1'b0;
      unf_q    <= 1'b0;
    end else if (flush_i) begin
      level_q  <= '0;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      ovf_q    <= 1'b0;
      unf_q    <= 1'b0;
    end else begin
      level_q  <= level_q + LVL_W'(n_wr) - LVL_W'(n_rd);
      wr_ptr_q <= wrap_add(wr_ptr_q, n_wr);
      rd_ptr_q <= wrap_add(rd_ptr_q, n_rd);
      ovf_q    <= ovf_q | ovf_hit;
      unf_q    <= unf_q | unf_hit;
    end
  end

  assign wr_ptr_o  = wr_ptr_q;
  assign rd_ptr_o  = rd_ptr_q;
  assign n_wr_o    = n_wr;
  assign rd_fire_o = act & reg_rd_i;
  assign rd_off_o  = e_out;
  assign rd_cnt_o  = CNT_W'(r_acc);
  assign level_o   = level_q;
  assign ovf_o     = ovf_q;
  assign unf_o     = unf_q;

  assert_level_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(level_q) <= DEPTH);
  assert_level_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |=> (int'(level_q) <= int'($past(level_q)) + LANES) &&
                 (int'(level_q) + LANES >= int'($past(level_q))));
  assert_full_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_q == LVL_W'(DEPTH) && !eng_pop_i && !reg_rd_i && !flush_i) |=>
    (level_q == LVL_W'(DEPTH)));
  assert_flush_empty_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (level_q == '0) && !ovf_q && !unf_q);
  assert_ovf_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !flush_i) |=> ovf_q);
  assert_unf_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unf_q && !flush_i) |=> unf_q);
endmodule

// File: rtl/pack_fifo_unpack.sv
module pack_fifo_unpack #(
  parameter int WB = 4,
  localparam int CNT_W = $clog2(WB + 1),
  localparam int LANES = WB + 1,
  localparam int LN_W  = $clog2(LANES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  fire_i,
  input  logic                  off_i,
  input  logic [CNT_W-1:0]      cnt_i,
  input  logic [LANES-1:0][7:0] rlanes_i,
  output logic [8*WB-1:0]       rdata_o
);
  logic [8*WB-1:0] nxt, rdata_q;

  always_comb begin
    for (int j = 0; j < WB; j++) begin
      nxt[8*j +: 8] = (j < int'(cnt_i)) ? rlanes_i[LN_W'(j + int'(off_i))] : 8'h00;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (fire_i) rdata_q <= nxt;
  end

  assign rdata_o = rdata_q;

  assert_rdata_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_i |=> $stable(rdata_q));
  assert_rdata_zero_hi_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && cnt_i == CNT_W'(1)) |=> (rdata_q[8*WB-1:8] == '0));
endmodule

// File: rtl/byte_pack_fifo.sv
module byte_pack_fifo
  import pack_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int WB    = WORD_BYTES,
  localparam int CNT_W = $clog2(WB + 1),
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int LANES = WB + 1,
  localparam int N_W   = $clog2(LANES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  input  logic             wr_i,
  input  logic [8*WB-1:0]  wdata_i,
  input  logic             rd_i,
  output logic [8*WB-1:0]  rdata_o,
  output logic [31:0]      stat_o,
  input  logic             eng_push_i,
  input  logic [7:0]       eng_din_i,
  output logic             eng_push_rdy_o,
  input  logic             eng_pop_i,
  output logic [7:0]       eng_dout_o,
  output logic             eng_pop_vld_o
);
  logic [CNT_W-1:0]      cnt, rd_cnt;
  logic [PTR_W-1:0]      wr_ptr, rd_ptr;
  logic [N_W-1:0]        n_wr;
  logic [LANES-1:0][7:0] wlanes, rlanes;
  logic                  rd_eff, rd_fire, rd_off, ovf, unf;
  logic [LVL_W-1:0]      level;

  // write wins when both data-port strobes are set
  assign rd_eff = rd_i & ~wr_i;

  pack_fifo_bcnt #(.WB(WB)) u_bcnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cnt_we_i),
    .wdata_i (cnt_wdata_i),
    .cnt_o   (cnt)
  );

  pack_fifo_ctrl #(.DEPTH(DEPTH), .WB(WB)) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .flush_i        (flush_i),
    .reg_wr_i       (wr_i),
    .reg_rd_i       (rd_eff),
    .cnt_i          (cnt),
    .wdata_i        (wdata_i),
    .eng_push_i     (eng_push_i),
    .eng_din_i      (eng_din_i),
    .eng_pop_i      (eng_pop_i),
    .eng_push_rdy_o (eng_push_rdy_o),
    .eng_pop_vld_o  (eng_pop_vld_o),
    .wr_ptr_o       (wr_ptr),
    .rd_ptr_o       (rd_ptr),
    .n_wr_o         (n_wr),
    .wlanes_o       (wlanes),
    .rd_fire_o      (rd_fire),
    .rd_off_o       (rd_off),
    .rd_cnt_o       (rd_cnt),
    .level_o        (level),
    .ovf_o          (ovf),
    .unf_o          (unf)
  );

  pack_fifo_store #(.DEPTH(DEPTH), .LANES(LANES)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_ptr_i (wr_ptr),
    .n_wr_i   (n_wr),
    .wlanes_i (wlanes),
    .rd_ptr_i (rd_ptr),
    .rlanes_o (rlanes)
  );

  pack_fifo_unpack #(.WB(WB)) u_unpack (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (rd_fire),
    .off_i    (rd_off),
    .cnt_i    (rd_cnt),
    .rlanes_i (rlanes),
    .rdata_o  (rdata_o)
  );

  always_comb begin
    stat_o                   = '0;
    stat_o[STAT_LVL_W-1:0]   = STAT_LVL_W'(level);
    stat_o[STAT_OVF_BIT]     = ovf;
    stat_o[STAT_UNF_BIT]     = unf;
  end

  assign cnt_o      = cnt;
  assign eng_dout_o = rlanes[0];

  assert_both_strobes_no_pop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && rd_i && !eng_pop_i && !flush_i) |=> (level >= $past(level)));
endmodule

// File: tb/byte_pack_fifo_test.sv
`timescale 1ns/1ps
module byte_pack_fifo_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flush_i = 1'b0;
  logic        cnt_we_i = 1'b0;
  logic [2:0]  cnt_wdata_i = '0;
  logic [2:0]  cnt_o;
  logic        wr_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic        rd_i = 1'b0;
  logic [31:0] rdata_o;
  logic [31:0] stat_o;
  logic        eng_push_i = 1'b0;
  logic [7:0]  eng_din_i = '0;
  logic        eng_push_rdy_o;
  logic        eng_pop_i = 1'b0;
  logic [7:0]  eng_dout_o;
  logic        eng_pop_vld_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  byte_pack_fifo uut (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush_i),
    .cnt_we_i(cnt_we_i), .cnt_wdata_i(cnt_wdata_i), .cnt_o(cnt_o),
    .wr_i(wr_i), .wdata_i(wdata_i), .rd_i(rd_i), .rdata_o(rdata_o),
    .stat_o(stat_o), .eng_push_i(eng_push_i), .eng_din_i(eng_din_i),
    .eng_push_rdy_o(eng_push_rdy_o), .eng_pop_i(eng_pop_i),
    .eng_dout_o(eng_dout_o), .eng_pop_vld_o(eng_pop_vld_o)
  );

  typedef struct packed {
    logic        rd;
    logic [2:0]  cnt;
    logic [31:0] data;
    logic [31:0] exp_rd;
    logic [7:0]  exp_lvl;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 3'd4, 32'h44332211, 32'h0,        8'd4},
    '{1'b0, 3'd2, 32'hAAAA6655, 32'h0,        8'd6},
    '{1'b0, 3'd1, 32'hFFFFFF77, 32'h0,        8'd7},
    '{1'b1, 3'd3, 32'h0,        32'h00332211, 8'd4},
    '{1'b1, 3'd4, 32'h0,        32'h77665544, 8'd0},
    '{1'b0, 3'd3, 32'h99CCBBAA, 32'h0,        8'd3},
    '{1'b1, 3'd1, 32'h0,        32'h000000AA, 8'd2},
    '{1'b1, 3'd2, 32'h0,        32'h0000CCBB, 8'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end right after a falling edge
  task automatic set_cnt(input logic [2:0] v);
    cnt_we_i = 1'b1; cnt_wdata_i = v;
    @(negedge clk);
    cnt_we_i = 1'b0;
  endtask

  task automatic do_wr(input logic [31:0] d);
    wr_i = 1'b1; wdata_i = d;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic do_rd();
    rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
  endtask

  task automatic eng_push(input logic [7:0] b);
    eng_push_i = 1'b1; eng_din_i = b;
    @(negedge clk);
    eng_push_i = 1'b0;
  endtask

  task automatic do_flush();
    flush_i = 1'b1;
    @(negedge clk);
    flush_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    chk("R1 stat", stat_o, 32'h0);
    chk("R1 cnt", 32'(cnt_o), 32'd4);
    chk("R1 rdata", rdata_o, 32'h0);
    chk("R1 push_rdy", 32'(eng_push_rdy_o), 32'd1);
    chk("R1 pop_vld", 32'(eng_pop_vld_o), 32'd0);

    // vector table: R3 packing, R4 unpacking, R5 level
    for (int i = 0; i < 8; i++) begin
      set_cnt(VECS[i].cnt);
      if (VECS[i].rd) begin
        do_rd();
        chk("R4 table rdata", rdata_o, VECS[i].exp_rd);
      end else begin
        do_wr(VECS[i].data);
      end
      chk("R5 table level", 32'(stat_o[7:0]), 32'(VECS[i].exp_lvl));
    end

    // R2 illegal byte counts ignored
    set_cnt(3'd3);
    set_cnt(3'd0);
    chk("R2 zero ignored", 32'(cnt_o), 32'd3);
    set_cnt(3'd5);
    chk("R2 five ignored", 32'(cnt_o), 32'd3);
    set_cnt(3'd1);
    chk("R2 one taken", 32'(cnt_o), 32'd1);

    // R6 R7 engine handshakes and same-cycle ordering
    eng_push(8'h10);
    eng_push(8'h20);
    chk("R6 level after eng push", 32'(stat_o[7:0]), 32'd2);
    chk("R7 pop_vld", 32'(eng_pop_vld_o), 32'd1);
    chk("R7 eng_dout oldest", 32'(eng_dout_o), 32'h10);
    set_cnt(3'd2);
    eng_push_i = 1'b1; eng_din_i = 8'h30; wr_i = 1'b1; wdata_i = 32'h00005040;
    @(negedge clk);
    eng_push_i = 1'b0; wr_i = 1'b0;
    chk("R5 joint push level", 32'(stat_o[7:0]), 32'd5);
    eng_pop_i = 1'b1; rd_i = 1'b1;
    @(negedge clk);
    eng_pop_i = 1'b0; rd_i = 1'b0;
    chk("R7 reg read after eng pop", rdata_o, 32'h00003020);
    chk("R5 joint pop level", 32'(stat_o[7:0]), 32'd2);
    chk("R6 eng byte ahead of reg bytes", 32'(eng_dout_o), 32'h40);
    eng_pop_i = 1'b1;
    @(negedge clk);
    chk("R7 next byte", 32'(eng_dout_o), 32'h50);
    @(negedge clk);
    eng_pop_i = 1'b0;
    chk("R7 empty pop_vld", 32'(eng_pop_vld_o), 32'd0);

    // R8 overflow at the full boundary
    set_cnt(3'd4);
    for (int k = 1; k <= 15; k++) do_wr({4{8'(k)}});
    set_cnt(3'd2);
    do_wr(32'h10101010);
    chk("R8 level 62", 32'(stat_o[7:0]), 32'd62);
    chk("R8 no ovf yet", 32'(stat_o[8]), 32'd0);
    set_cnt(3'd4);
    do_wr(32'hDDCCBBAA);
    chk("R8 level full", 32'(stat_o[7:0]), 32'd64);
    chk("R8 ovf set", 32'(stat_o[8]), 32'd1);
    chk("R6 push_rdy low when full", 32'(eng_push_rdy_o), 32'd0);
    eng_push(8'hEE);
    chk("R6 full eng push dropped", 32'(stat_o[7:0]), 32'd64);
    for (int k = 1; k <= 15; k++) begin
      do_rd();
      if (k == 1) begin
        chk("R8 first word", rdata_o, 32'h01010101);
        chk("R8 ovf sticky", 32'(stat_o[8]), 32'd1);
      end
    end
    do_rd();
    chk("R8 tail excess dropped", rdata_o, 32'hBBAA1010);
    chk("R8 drained", 32'(stat_o[7:0]), 32'd0);

    // R9 underflow
    do_rd();
    chk("R9 empty read zeros", rdata_o, 32'h0);
    chk("R9 unf set", 32'(stat_o[9]), 32'd1);
    do_flush();
    chk("R10 flush clears flags", stat_o, 32'h0);
    set_cnt(3'd2);
    do_wr(32'hFFFF2211);
    set_cnt(3'd4);
    do_rd();
    chk("R9 partial read zero fill", rdata_o, 32'h00002211);
    chk("R9 partial unf", stat_o, 32'h00000200);
    do_flush();

    // R10 flush beats same-cycle operations
    set_cnt(3'd1);
    do_wr(32'h0000005A);
    chk("R10 level before flush", 32'(stat_o[7:0]), 32'd1);
    flush_i = 1'b1; wr_i = 1'b1; wdata_i = 32'h0000005B; eng_push_i = 1'b1; rd_i = 1'b1;
    @(negedge clk);
    flush_i = 1'b0; wr_i = 1'b0; eng_push_i = 1'b0; rd_i = 1'b0;
    chk("R10 flush wins", stat_o, 32'h0);
    chk("R10 rdata held", rdata_o, 32'h00002211);

    // R11 write beats read
    do_wr(32'h00000055);
    wr_i = 1'b1; rd_i = 1'b1; wdata_i = 32'h00000066;
    @(negedge clk);
    wr_i = 1'b0; rd_i = 1'b0;
    chk("R11 level after joint strobes", 32'(stat_o[7:0]), 32'd2);
    chk("R11 rdata held", rdata_o, 32'h00002211);
    set_cnt(3'd2);
    do_rd();
    chk("R11 both bytes kept", rdata_o, 32'h00006655);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule